// File: doc/BRIEF.md
# Instruction Address Match Breakpoint Unit

This block watches the start address of every instruction the processor is about to execute and compares it against four programmable match channels. Each channel holds a 20-bit address and an enable bit. When an accepted instruction-start beat carries an address equal to an enabled channel, the block raises an interrupt request before that instruction runs. The request does not depend on the global interrupt-enable flag or on the current priority level. The block has no masking input of any kind.

Along with the request, the block reports the number of the channel that matched. It also reports the program-counter value the processor should push. That value is deliberately not the true return address. It is the match address plus 2 for instructions of the long opcode class, and plus 1 for every other instruction. The opcode class arrives with the beat. Software corrects the stacked value before it returns.

Instruction-start beats use a valid/ready handshake, and a beat is taken on a clock edge where both are high. `ist_ready` is low while a request is pending, so the fetch side must hold its beat and must not change `ist_addr`, `ist_long_op` or `ist_ext_area` while valid is high and ready is low. A pending request stays up until the processor pulses `irq_ack`. The match registers sit behind a plain register port: writes are synchronous and reads are combinational.

Top module: `addr_match_unit`

## Requirements
- R1: After reset, all four match addresses read as 0 and all enable bits read as 0. `irq_pulse` and `irq_pending` are 0, and `ist_ready` is 1.
- R2: With `reg_we` high, `reg_sel` values 0 to 3 write the match address of that channel, and `reg_sel` = 4 writes the enable bits from `reg_wdata[3:0]` (bit i enables channel i). `reg_rdata` returns the selected register with its unused upper bits at zero.
- R3: When a beat is accepted whose address equals the address of an enabled channel, `irq_pulse` and `irq_pending` are high in the cycle after acceptance. In that same cycle `irq_chan` holds the channel number.
- R4: No request is raised for a disabled channel, for an address that equals no enabled channel, or while `ist_valid` is low, even if `ist_addr` equals a match address.
- R5: When several enabled channels hold the same address, `irq_chan` reports the lowest-numbered one.
- R6: In the cycle of `irq_pulse`, `irq_ret_pc` equals the match address plus 2 when `ist_long_op` was 1, and plus 1 when it was 0. The sum wraps modulo 2^20.
- R7: When `cfg_ext_bus8` is 1 and `ist_ext_area` is 1, no request is raised. Either bit alone does not suppress a match.
- R8: `irq_pulse` lasts exactly one cycle. `irq_pending` stays high and `ist_ready` stays low until an `irq_ack` cycle. After that cycle, `irq_pending` is 0 and `ist_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0-3 match address, 4 enable bits |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Selected register contents |
| cfg_ext_bus8 | input | 1 | External bus configured 8 bits wide |
| ist_valid | input | 1 | Instruction-start beat valid |
| ist_ready | output | 1 | Block can accept a beat |
| ist_addr | input | 20 | Start address of the instruction |
| ist_long_op | input | 1 | Opcode class: 1 selects the +2 return offset |
| ist_ext_area | input | 1 | Address lies in the external area |
| irq_ack | input | 1 | Processor has taken the request |
| irq_pulse | output | 1 | One-cycle request strobe |
| irq_pending | output | 1 | Request outstanding until acknowledged |
| irq_chan | output | 2 | Index of the matching channel |
| irq_ret_pc | output | 20 | Program-counter value to stack |

## Verification
The assertions assume that `irq_ack` is raised only while a request is pending. They also assume that a match register is not rewritten in the same cycle as a beat that matches it. The bench follows both rules: it programs the registers while no beat is offered, and it acknowledges only after it has observed `irq_pending` high. It drives every beat and every acknowledge on the falling edge, and it holds the beat fields steady until the handshake completes.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int unsigned AMU_CHANNELS = 4;
  localparam int unsigned AMU_ADDR_W   = 20;
  localparam int unsigned AMU_SEL_W    = $clog2(AMU_CHANNELS + 1);
  localparam int unsigned AMU_CHAN_W   = (AMU_CHANNELS > 1) ? $clog2(AMU_CHANNELS) : 1;
endpackage

// File: rtl/amu_regfile.sv
module amu_regfile #(
  parameter int unsigned N     = 4,
  parameter int unsigned AW    = 20,
  parameter int unsigned SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [AW-1:0]        wdata,
  output logic [AW-1:0]        rdata,
  output logic [N-1:0][AW-1:0] match_addr,
  output logic [N-1:0]         match_en
);
  localparam logic [SEL_W-1:0] EN_SEL = SEL_W'(N);

  for (genvar g = 0; g < N; g++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                match_addr[g] <= '0;
      else if (we && (sel == SEL_W'(g)))        match_addr[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        match_en <= '0;
    else if (we && (sel == EN_SEL))    match_en <= wdata[N-1:0];
  end

  always_comb begin
    rdata = '0;
    if (sel == EN_SEL) rdata[N-1:0] = match_en;
    else begin
      for (int i = 0; i < N; i++)
        if (sel == SEL_W'(i)) rdata = match_addr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && $past(rst_n) && $past(we) && ($past(sel) == EN_SEL))
      assert_en_written_R2: assert (match_en == $past(wdata[N-1:0]));
  end
endmodule

// File: rtl/amu_match_array.sv
module amu_match_array #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0][AW-1:0] match_addr,
  input  logic [N-1:0]         match_en,
  input  logic [AW-1:0]        probe_addr,
  output logic                 any_hit,
  output logic [CW-1:0]        hit_chan
);
  logic [N-1:0] hit_vec;
  logic [N-1:0] grant;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = match_en[g] && (match_addr[g] == probe_addr);
  end

  // lowest channel number wins
  always_comb begin
    grant    = '0;
    hit_chan = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit_chan = CW'(i);
      end
    end
  end

  assign any_hit = |hit_vec;

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_hit == (grant != '0)));
endmodule

// File: rtl/amu_req_ctrl.sv
module amu_req_ctrl #(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [CW-1:0] fire_chan,
  input  logic [AW-1:0] fire_addr,
  input  logic          fire_long,
  input  logic          ack,
  output logic          pulse,
  output logic          pending,
  output logic [CW-1:0] chan_q,
  output logic [AW-1:0] ret_pc
);
  logic [AW-1:0] offset;
  assign offset = fire_long ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse   <= 1'b0;
      pending <= 1'b0;
      chan_q  <= '0;
      ret_pc  <= '0;
    end else begin
      pulse <= fire;
      if (fire) begin
        pending <= 1'b1;
        chan_q  <= fire_chan;
        ret_pc  <= fire_addr + offset;
      end else if (ack) begin
        pending <= 1'b0;
      end
    end
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
  assert_pulse_sets_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> pending);
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit #(
  parameter int unsigned NUM_CH = amu_pkg::AMU_CHANNELS,
  parameter int unsigned ADDR_W = amu_pkg::AMU_ADDR_W,
  parameter int unsigned SEL_W  = amu_pkg::AMU_SEL_W,
  parameter int unsigned CHAN_W = amu_pkg::AMU_CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              cfg_ext_bus8,
  input  logic              ist_valid,
  output logic              ist_ready,
  input  logic [ADDR_W-1:0] ist_addr,
  input  logic              ist_long_op,
  input  logic              ist_ext_area,
  input  logic              irq_ack,
  output logic              irq_pulse,
  output logic              irq_pending,
  output logic [CHAN_W-1:0] irq_chan,
  output logic [ADDR_W-1:0] irq_ret_pc
);
  logic [NUM_CH-1:0][ADDR_W-1:0] match_addr;
  logic [NUM_CH-1:0]             match_en;
  logic                          any_hit;
  logic [CHAN_W-1:0]             hit_chan;
  logic                          accept;
  logic                          blocked;
  logic                          fire;

  amu_regfile #(.N(NUM_CH), .AW(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .match_addr(match_addr), .match_en(match_en)
  );

  amu_match_array #(.N(NUM_CH), .AW(ADDR_W), .CW(CHAN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .match_addr(match_addr), .match_en(match_en),
    .probe_addr(ist_addr), .any_hit(any_hit), .hit_chan(hit_chan)
  );

  assign ist_ready = !irq_pending;
  assign accept    = ist_valid && ist_ready;
  assign blocked   = cfg_ext_bus8 && ist_ext_area;
  assign fire      = accept && any_hit && !blocked;

  amu_req_ctrl #(.AW(ADDR_W), .CW(CHAN_W)) u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_chan(hit_chan),
    .fire_addr(ist_addr), .fire_long(ist_long_op), .ack(irq_ack),
    .pulse(irq_pulse), .pending(irq_pending), .chan_q(irq_chan),
    .ret_pc(irq_ret_pc)
  );

  assert_only_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ist_valid));
  assert_ext8_suppressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(cfg_ext_bus8 && ist_ext_area));
  assert_retpc_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ((irq_ret_pc == $past(ist_addr) + ADDR_W'(1)) ||
                   (irq_ret_pc == $past(ist_addr) + ADDR_W'(2))));
  assert_chan_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> match_en[irq_chan]);
endmodule

// File: tb/sim_addr_match_unit.sv
module sim_addr_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic        cfg_ext_bus8 = 1'b0;
  logic        ist_valid = 1'b0;
  logic        ist_ready;
  logic [19:0] ist_addr = '0;
  logic        ist_long_op = 1'b0;
  logic        ist_ext_area = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_pulse;
  logic        irq_pending;
  logic [1:0]  irq_chan;
  logic [19:0] irq_ret_pc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  addr_match_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_ext_bus8(cfg_ext_bus8),
    .ist_valid(ist_valid), .ist_ready(ist_ready), .ist_addr(ist_addr),
    .ist_long_op(ist_long_op), .ist_ext_area(ist_ext_area), .irq_ack(irq_ack),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending), .irq_chan(irq_chan),
    .irq_ret_pc(irq_ret_pc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // offer one beat; returns on the falling edge after acceptance
  task automatic beat(input logic [19:0] a, input logic lng, input logic ext);
    @(negedge clk);
    ist_valid = 1'b1; ist_addr = a; ist_long_op = lng; ist_ext_area = ext;
    while (!ist_ready) @(negedge clk);
    @(negedge clk);
    ist_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [1:0] ch,
                            input logic [19:0] pc);
    check(irq_pulse === 1'b1, {tag, " pulse"}, 32'(irq_pulse), 1);
    check(irq_chan === ch, {tag, " chan"}, 32'(irq_chan), 32'(ch));
    check(irq_ret_pc === pc, {tag, " retpc"}, 32'(irq_ret_pc), 32'(pc));
  endtask

  task automatic expect_none(input string tag);
    check(irq_pulse === 1'b0 && irq_pending === 1'b0, tag,
          {30'd0, irq_pulse, irq_pending}, 0);
  endtask

  task automatic do_ack();
    @(negedge clk);
    check(irq_pulse === 1'b0, "R8 pulse one cycle", 32'(irq_pulse), 0);
    check(irq_pending === 1'b1 && ist_ready === 1'b0, "R8 pending holds",
          {30'd0, irq_pending, ist_ready}, 2);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq_pending === 1'b0 && ist_ready === 1'b1, "R8 cleared by ack",
          {30'd0, irq_pending, ist_ready}, 1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) begin
      reg_sel = 3'(i);
      #1;
      check(reg_rdata === 20'h0, "R1 register reset", 32'(reg_rdata), 0);
    end
    check(irq_pulse === 0 && irq_pending === 0 && ist_ready === 1, "R1 outputs",
          {29'd0, irq_pulse, irq_pending, ist_ready}, 1);
  endtask

  task automatic t_regs();
    wr(3'd0, 20'h01000); wr(3'd1, 20'h02000);
    wr(3'd2, 20'h03000); wr(3'd3, 20'hFFFFF);
    wr(3'd4, 20'hFFFF5);
    @(negedge clk);
    reg_sel = 3'd2; #1;
    check(reg_rdata === 20'h03000, "R2 address readback", 32'(reg_rdata), 32'h03000);
    reg_sel = 3'd4; #1;
    check(reg_rdata === 20'h00005, "R2 enable readback", 32'(reg_rdata), 5);
  endtask

  task automatic t_basic();
    beat(20'h01000, 1'b0, 1'b0);
    expect_hit("R3 channel 0 short", 2'd0, 20'h01001);
    do_ack();
    beat(20'h03000, 1'b1, 1'b0);
    expect_hit("R6 channel 2 long", 2'd2, 20'h03002);
    do_ack();
  endtask

  task automatic t_nofire();
    beat(20'h02000, 1'b0, 1'b0);
    expect_none("R4 disabled channel");
    beat(20'h01001, 1'b0, 1'b0);
    expect_none("R4 mid-instruction address");
    @(negedge clk);
    ist_addr = 20'h01000;
    repeat (2) @(negedge clk);
    expect_none("R4 no strobe");
  endtask

  task automatic t_priority();
    wr(3'd1, 20'h03000); wr(3'd4, 20'h0000E);
    beat(20'h03000, 1'b0, 1'b0);
    expect_hit("R5 lowest wins", 2'd1, 20'h03001);
    do_ack();
  endtask

  task automatic t_wrap();
    beat(20'hFFFFF, 1'b1, 1'b0);
    expect_hit("R6 wrap", 2'd3, 20'h00001);
    do_ack();
  endtask

  task automatic t_ext();
    cfg_ext_bus8 = 1'b1;
    beat(20'h03000, 1'b0, 1'b1);
    expect_none("R7 suppressed");
    beat(20'h03000, 1'b0, 1'b0);
    expect_hit("R7 bus8 internal", 2'd1, 20'h03001);
    do_ack();
    cfg_ext_bus8 = 1'b0;
    beat(20'h03000, 1'b1, 1'b1);
    expect_hit("R7 ext wide bus", 2'd1, 20'h03002);
    do_ack();
  endtask

  task automatic t_backpressure();
    beat(20'h03000, 1'b0, 1'b0);
    expect_hit("R8 first", 2'd1, 20'h03001);
    @(negedge clk);
    ist_valid = 1'b1; ist_addr = 20'hFFFFF; ist_long_op = 1'b0; ist_ext_area = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_pulse === 1'b0 && ist_ready === 1'b0, "R8 held off",
          {30'd0, irq_pulse, ist_ready}, 0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    ist_valid = 1'b0;
    expect_hit("R8 after ack", 2'd3, 20'h00000);
    do_ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_nofire();
    t_priority();
    t_wrap();
    t_ext();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule